// File: doc/BRIEF.md
# Complementary PWM Deadtime Generator

The block takes a pair of raw PWM channel waveforms and turns one chosen source into a top/bottom pair for a half-bridge. The two outputs are never active together. After every switching edge of the source, both outputs stay inactive for a programmable number of clocks before the newly active side turns on. The rising and falling directions each have their own deadtime count and their own down-counter. A polarity control picks which raw channel is the source. A double-switching enable replaces that choice with an alternate waveform. An independent-mode control bypasses the pairing completely and routes each raw channel straight to its own output.

The controller is a five-state machine.

- ST_HOLD is entered on reset and whenever independent mode is selected. Both paired outputs are inactive in this state.
- On the first clock with independent mode off, ST_HOLD treats the current source level as an edge. It goes to ST_DEAD_RISE if the source is high and to ST_DEAD_FALL if it is low.
- A rising edge moves the machine from ST_BOT_ON or ST_DEAD_FALL into ST_DEAD_RISE and loads the rising counter.
- A falling edge moves the machine from ST_TOP_ON or ST_DEAD_RISE into ST_DEAD_FALL and loads the falling counter.
- ST_DEAD_RISE goes to ST_TOP_ON when its counter reads zero.
- ST_DEAD_FALL goes to ST_BOT_ON when its counter reads zero.
- From every state, independent mode returns the machine to ST_HOLD.

Reset is synchronous and active high.

Top module: `pwm_deadtime_gen`

## Requirements
- R1: While rst is high, and on the clock after it, both outputs are 0 when independent mode is off. On the first clock after reset, the source level is treated as an edge: with the source low, out_bot goes to 1 exactly dt_fall+1 clocks after that first clock.
- R2: While indep_mode is 0, out_top and out_bot are never both 1.
- R3: A rising edge of the source is detected at clock edge k. If the source stays high, out_top becomes 1 right after clock edge k+dt_rise+1 and stays 1 while the source stays high.
- R4: A falling edge of the source is detected at clock edge k. If the source stays low, out_bot becomes 1 right after clock edge k+dt_fall+1 and stays 1 while the source stays low.
- R5: The output that turns off goes to 0 right after the clock edge at which the source edge is detected. Only the output that turns on is delayed.
- R6: If the opposite edge arrives while a deadtime count is still running, that count is abandoned. Both outputs stay 0 until the new direction's count expires, measured from the new edge.
- R7: While indep_mode is 1, out_top equals raw_a and out_bot equals raw_b in the same cycle, with no clock delay. When indep_mode returns to 0, the pair restarts from the source level through a full deadtime.
- R8: With dbl_en=0, pol_sel=0 makes raw_a the source and pol_sel=1 makes raw_b the source. The unselected channel has no effect on the outputs.
- R9: With dbl_en=1, dbl_src is the source whatever pol_sel is, and neither raw channel affects the outputs.
- R10: A deadtime count of 0 gives exactly one clock with both outputs 0 after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| raw_a | input | 1 | Raw PWM channel A (paired source when pol_sel=0) |
| raw_b | input | 1 | Raw PWM channel B (paired source when pol_sel=1) |
| dbl_src | input | 1 | Alternate double-switching PWM waveform |
| indep_mode | input | 1 | 1 = bypass the pairing, route each raw channel to its own output |
| dbl_en | input | 1 | 1 = use dbl_src as the paired source |
| pol_sel | input | 1 | Chooses which raw channel is the paired source |
| dt_rise | input | CNT_W | Deadtime clocks before out_top turns on |
| dt_fall | input | CNT_W | Deadtime clocks before out_bot turns on |
| out_top | output | 1 | Top switch drive |
| out_bot | output | 1 | Bottom switch drive |

## Verification
A wrong state or a bad counter value shows up at the ports as a turn-on that comes one or more clocks early or late compared with the edge time plus the programmed count. An overlap of the two outputs is another sign, and it appears in the very cycle the machine goes wrong. A lost abandonment also shows at the ports: after an opposite edge, the stale counter lets the old side turn on even though the source has already gone back. The sweeps over every pulse width shorter and longer than the counts expose these faults within the same pulse.

// File: rtl/pdt_pkg.sv
package pdt_pkg;

    typedef enum logic [2:0] {
        ST_HOLD,
        ST_DEAD_RISE,
        ST_TOP_ON,
        ST_DEAD_FALL,
        ST_BOT_ON
    } pdt_state_t;

    localparam int DIR_FALL = 0;
    localparam int DIR_RISE = 1;
    localparam int NUM_DIR  = 2;

endpackage

// File: rtl/pdt_src_sel.sv
module pdt_src_sel (
    input  logic clk,
    input  logic rst,
    input  logic raw_a,
    input  logic raw_b,
    input  logic dbl_src,
    input  logic dbl_en,
    input  logic pol_sel,
    output logic src_lvl,
    output logic rise_evt,
    output logic fall_evt
);

    logic chan_pick;
    logic src_q;

    always_comb begin
        chan_pick = pol_sel ? raw_b : raw_a;
        src_lvl   = dbl_en ? dbl_src : chan_pick;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            src_q <= 1'b0;
        end else begin
            src_q <= src_lvl;
        end
    end

    always_comb begin
        rise_evt = src_lvl & ~src_q;
        fall_evt = ~src_lvl & src_q;
    end

endmodule

// File: rtl/pdt_dt_counter.sv
module pdt_dt_counter #(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             is_zero
);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign is_zero = (cnt == '0);

endmodule

// File: rtl/pdt_fsm.sv
module pdt_fsm
    import pdt_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic indep_mode,
    input  logic src_lvl,
    input  logic rise_evt,
    input  logic fall_evt,
    input  logic zero_rise,
    input  logic zero_fall,
    output logic load_rise,
    output logic load_fall,
    output logic fsm_top,
    output logic fsm_bot
);

    pdt_state_t state, state_nxt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_HOLD;
        end else begin
            state <= state_nxt;
        end
    end

    always_comb begin
        state_nxt = state;
        load_rise = 1'b0;
        load_fall = 1'b0;
        if (indep_mode) begin
            state_nxt = ST_HOLD;
        end else begin
            unique case (state)
                ST_HOLD: begin
                    if (src_lvl) begin
                        state_nxt = ST_DEAD_RISE;
                        load_rise = 1'b1;
                    end else begin
                        state_nxt = ST_DEAD_FALL;
                        load_fall = 1'b1;
                    end
                end
                ST_DEAD_RISE: begin
                    if (fall_evt) begin
                        state_nxt = ST_DEAD_FALL;
                        load_fall = 1'b1;
                    end else if (zero_rise) begin
                        state_nxt = ST_TOP_ON;
                    end
                end
                ST_TOP_ON: begin
                    if (fall_evt) begin
                        state_nxt = ST_DEAD_FALL;
                        load_fall = 1'b1;
                    end
                end
                ST_DEAD_FALL: begin
                    if (rise_evt) begin
                        state_nxt = ST_DEAD_RISE;
                        load_rise = 1'b1;
                    end else if (zero_fall) begin
                        state_nxt = ST_BOT_ON;
                    end
                end
                ST_BOT_ON: begin
                    if (rise_evt) begin
                        state_nxt = ST_DEAD_RISE;
                        load_rise = 1'b1;
                    end
                end
                default: begin
                    state_nxt = ST_HOLD;
                end
            endcase
        end
    end

    always_comb begin
        fsm_top = 1'b0;
        fsm_bot = 1'b0;
        unique case (state)
            ST_TOP_ON: fsm_top = 1'b1;
            ST_BOT_ON: fsm_bot = 1'b1;
            default: begin
                fsm_top = 1'b0;
                fsm_bot = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/pwm_deadtime_gen.sv
module pwm_deadtime_gen
    import pdt_pkg::*;
#(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             raw_a,
    input  logic             raw_b,
    input  logic             dbl_src,
    input  logic             indep_mode,
    input  logic             dbl_en,
    input  logic             pol_sel,
    input  logic [CNT_W-1:0] dt_rise,
    input  logic [CNT_W-1:0] dt_fall,
    output logic             out_top,
    output logic             out_bot
);

    logic src_lvl, rise_evt, fall_evt;
    logic fsm_top, fsm_bot;
    logic [NUM_DIR-1:0]   cnt_load;
    logic [NUM_DIR-1:0]   cnt_zero;
    logic [CNT_W-1:0]     cnt_val [NUM_DIR];

    assign cnt_val[DIR_RISE] = dt_rise;
    assign cnt_val[DIR_FALL] = dt_fall;

    pdt_src_sel u_src (
        .clk      (clk),
        .rst      (rst),
        .raw_a    (raw_a),
        .raw_b    (raw_b),
        .dbl_src  (dbl_src),
        .dbl_en   (dbl_en),
        .pol_sel  (pol_sel),
        .src_lvl  (src_lvl),
        .rise_evt (rise_evt),
        .fall_evt (fall_evt)
    );

    for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
        pdt_dt_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk      (clk),
            .rst      (rst),
            .load     (cnt_load[d]),
            .load_val (cnt_val[d]),
            .is_zero  (cnt_zero[d])
        );
    end

    pdt_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .indep_mode (indep_mode),
        .src_lvl    (src_lvl),
        .rise_evt   (rise_evt),
        .fall_evt   (fall_evt),
        .zero_rise  (cnt_zero[DIR_RISE]),
        .zero_fall  (cnt_zero[DIR_FALL]),
        .load_rise  (cnt_load[DIR_RISE]),
        .load_fall  (cnt_load[DIR_FALL]),
        .fsm_top    (fsm_top),
        .fsm_bot    (fsm_bot)
    );

    always_comb begin
        if (indep_mode) begin
            out_top = raw_a;
            out_bot = raw_b;
        end else begin
            out_top = fsm_top;
            out_bot = fsm_bot;
        end
    end

endmodule

// File: rtl/pdt_checker.sv
module pdt_checker (
    input logic clk,
    input logic rst,
    input logic indep_mode,
    input logic dbl_en,
    input logic dbl_src,
    input logic src_lvl,
    input logic fall_evt,
    input logic rise_evt,
    input logic out_top,
    input logic out_bot
);

    assert_no_overlap_R2: assert property (@(posedge clk) disable iff (rst)
        !indep_mode |-> !(out_top && out_bot));

    assert_top_after_high_R3: assert property (@(posedge clk) disable iff (rst)
        (!indep_mode && $past(!indep_mode) && $rose(out_top))
        |-> ($past(src_lvl) && $past(src_lvl, 2)));

    assert_bot_after_low_R4: assert property (@(posedge clk) disable iff (rst)
        (!indep_mode && $past(!indep_mode) && $rose(out_bot))
        |-> (!$past(src_lvl) && !$past(src_lvl, 2)));

    assert_fall_kills_top_R5: assert property (@(posedge clk) disable iff (rst)
        (fall_evt && !indep_mode) |=> (indep_mode || !out_top));

    assert_rise_kills_bot_R5: assert property (@(posedge clk) disable iff (rst)
        (rise_evt && !indep_mode) |=> (indep_mode || !out_bot));

    assert_dbl_source_R9: assert property (@(posedge clk) disable iff (rst)
        ($fell(dbl_src) && dbl_en && $past(dbl_en) && !indep_mode)
        |=> (indep_mode || !out_top));

endmodule

bind pwm_deadtime_gen pdt_checker u_pdt_chk (
    .clk        (clk),
    .rst        (rst),
    .indep_mode (indep_mode),
    .dbl_en     (dbl_en),
    .dbl_src    (dbl_src),
    .src_lvl    (src_lvl),
    .fall_evt   (fall_evt),
    .rise_evt   (rise_evt),
    .out_top    (out_top),
    .out_bot    (out_bot)
);

// File: tb/pwm_deadtime_gen_test.sv
module pwm_deadtime_gen_test;

    localparam int CNT_W = 11;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic raw_a = 1'b0, raw_b = 1'b0, dbl_src = 1'b0;
    logic indep_mode = 1'b0, dbl_en = 1'b0, pol_sel = 1'b0;
    logic [CNT_W-1:0] dt_rise = 3, dt_fall = 2;
    logic out_top, out_bot;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // reference model state
    bit m_active = 0;
    bit m_dir = 0;
    bit m_sq = 0;
    int m_age = 0;
    int m_d = 0;

    always #4 clk = ~clk;

    pwm_deadtime_gen #(.CNT_W(CNT_W)) uut (
        .clk(clk), .rst(rst), .raw_a(raw_a), .raw_b(raw_b), .dbl_src(dbl_src),
        .indep_mode(indep_mode), .dbl_en(dbl_en), .pol_sel(pol_sel),
        .dt_rise(dt_rise), .dt_fall(dt_fall), .out_top(out_top), .out_bot(out_bot)
    );

    function automatic bit cur_src();
        if (dbl_en) return dbl_src;
        if (pol_sel) return raw_b;
        return raw_a;
    endfunction

    task automatic chk(input string tag, input logic act, input logic exp, input string what);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0b expected=%0b t=%0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic model_step();
        bit s;
        s = cur_src();
        if (rst) begin
            m_active = 0;
            s = 0;
        end else if (indep_mode) begin
            m_active = 0;
        end else if (!m_active || s != m_sq) begin
            m_active = 1;
            m_dir = s;
            m_age = 0;
            m_d = s ? int'(dt_rise) : int'(dt_fall);
        end else if (m_age < 100000) begin
            m_age++;
        end
        m_sq = s;
    endtask

    task automatic check_outputs(input string tag);
        logic et, eb;
        string t;
        if (indep_mode) begin
            chk("R7", out_top, raw_a, "indep top");
            chk("R7", out_bot, raw_b, "indep bot");
        end else begin
            et = m_active && m_dir && (m_age >= m_d + 1);
            eb = m_active && !m_dir && (m_age >= m_d + 1);
            t = (m_active && m_age == 0) ? "R5" : tag;
            chk(t, out_top, et, "top");
            chk(t, out_bot, eb, "bot");
            chk("R2", out_top && out_bot, 1'b0, "overlap");
        end
    endtask

    task automatic tick(input string tag);
        @(posedge clk);
        model_step();
        @(negedge clk);
        check_outputs(tag);
    endtask

    task automatic set_src(input logic v);
        raw_a = 1'($urandom);
        raw_b = 1'($urandom);
        dbl_src = 1'($urandom);
        if (dbl_en) dbl_src = v;
        else if (pol_sel) raw_b = v;
        else raw_a = v;
    endtask

    task automatic pulses(input string tag, input int maxw);
        for (int hw = 1; hw <= maxw; hw++) begin
            for (int lw = 1; lw <= maxw; lw++) begin
                for (int i = 0; i < hw; i++) begin
                    set_src(1'b1);
                    tick(tag);
                end
                for (int i = 0; i < lw; i++) begin
                    set_src(1'b0);
                    tick(tag);
                end
            end
        end
    endtask

    initial begin
        int rv[4];
        int fv[3];
        rv = '{0, 1, 2, 5};
        fv = '{0, 1, 3};
        @(negedge clk);
        // R1: reset with source high, then release with source low
        raw_a = 1'b1;
        for (int i = 0; i < 4; i++) tick("R1");
        chk("R1", out_top, 1'b0, "reset top");
        chk("R1", out_bot, 1'b0, "reset bot");
        rst = 1'b0;
        raw_a = 1'b0;
        for (int i = 0; i < 8; i++) tick("R1");

        // R3/R4: sweep counts and pulse widths, source raw_a
        foreach (rv[i]) begin
            foreach (fv[j]) begin
                dt_rise = CNT_W'(rv[i]);
                dt_fall = CNT_W'(fv[j]);
                pulses((rv[i] > fv[j]) ? "R3" : "R4", 8);
            end
        end

        // R10: zero deadtime
        dt_rise = 0; dt_fall = 0;
        pulses("R10", 4);

        // R6: pulses shorter than deadtime abandon counts
        dt_rise = 6; dt_fall = 5;
        pulses("R6", 8);

        // R8: raw_b selected, raw_a noise
        pol_sel = 1'b1; dt_rise = 2; dt_fall = 4;
        pulses("R8", 6);

        // R9: double-switching source overrides channels
        dbl_en = 1'b1; dt_rise = 3; dt_fall = 1;
        pulses("R9", 6);
        pol_sel = 1'b0;
        pulses("R9", 4);
        dbl_en = 1'b0;

        // R7: independent bypass over all channel pairs
        indep_mode = 1'b1;
        for (int k = 0; k < 32; k++) begin
            raw_a = k[0];
            raw_b = k[1];
            tick("R7");
        end
        // leave independent mode with source high
        raw_a = 1'b1;
        indep_mode = 1'b0;
        dt_rise = 4;
        for (int i = 0; i < 12; i++) tick("R7");

        // R1: reset mid-run while top is active
        rst = 1'b1;
        tick("R1");
        chk("R1", out_top, 1'b0, "reset clears top");
        rst = 1'b0;
        for (int i = 0; i < 10; i++) tick("R1");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule